// File: doc/BRIEF.md
# Long-Range Spread-Spectrum Transmit Framer

This block builds the transmit symbol stream for a narrowband, long-range FSK link. A frame starts straight away with a fixed 64-bit synchronisation word and has no preamble. The word is sent M+1 times. The first M copies are bit-inverted and the last copy is sent true. A receiver uses this repetition to track frequency offset at very low SNR. The payload bytes then pass through a rate-1/2, constraint-length-7 convolutional encoder. Six zero flush bits follow the last payload bit, and each coded bit is spread into SF chips. Each information bit therefore costs 2×SF air symbols, so the information rate is the symbol rate divided by 2×SF.

Bytes arrive over a valid/ready interface. An external strobe at the modulation symbol rate paces the output, and each strobe releases at most one symbol. The spreading factor is chosen at start. The repetition count M comes from a small configuration register that resets to 2. Both values are latched when the frame starts. A spreading code that would mean a factor of 1 is refused with an error pulse.

Top module: `lr_spread_framer`

## Requirements
- R1: A start request with `sfSel` = 2'b00 (factor 1, unsupported) raises `cfgErr` for exactly one cycle, leaves `busy` low and emits no symbols.
- R2: The repetition register holds M = 2 after reset and takes `cfgRep` on any cycle where `cfgWr` is high. The value in the register when a frame starts is used for that whole frame.
- R3: A frame begins with no preamble. Its first (M+1)×64 symbols are the word 0xCCC3C3CCC33C3333, sent bit 0 first. The first M copies are inverted, and the syncword symbols are neither coded nor spread.
- R4: Payload bytes are serialised bit 0 first into a convolutional encoder whose state is zero at frame start. With u the current bit and p1..p6 the previous bits (p1 most recent), the first coded bit is u^p1^p2^p3^p6 (octal 171) and the second is u^p2^p3^p5^p6 (octal 133).
- R5: After the last bit of the byte marked with `inLast`, six zero bits are encoded to flush the encoder.
- R6: `sfSel` 2'b01, 2'b10 and 2'b11 select SF = 2, 4 and 8. A coded 0 becomes SF chips 1,0,1,0,… and a coded 1 becomes the complement 0,1,0,1,….
- R7: Each `symStrobe` seen while a symbol is ready yields one symbol: `symValid` is high for one cycle, the cycle after the strobe, with `symOut` holding it. Strobes that arrive while idle, or while waiting for payload, produce nothing.
- R8: `inReady` is low while idle, in the cycle after a byte is accepted, and after the byte marked `inLast` has been accepted.
- R9: `done` pulses for one cycle together with the `symValid` of the final flush chip, and `busy` falls in that same cycle.
- R10: A start request made while `busy` is high is ignored. It raises no error and does not change the frame in progress.
- R11: A frame of N bytes emits exactly (M+1)×64 + (8N+6)×2×SF symbols.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWr | input | 1 | Write strobe for the repetition register |
| cfgRep | input | REP_W | New repetition count M |
| startReq | input | 1 | Start a frame (taken only while idle) |
| sfSel | input | 2 | Spreading code: 01=2, 10=4, 11=8, 00 rejected |
| inData | input | 8 | Payload byte |
| inValid | input | 1 | Payload byte valid |
| inLast | input | 1 | Marks the final payload byte |
| inReady | output | 1 | Framer can take a byte |
| symStrobe | input | 1 | Symbol-rate pacing strobe |
| symOut | output | 1 | Current air symbol |
| symValid | output | 1 | One-cycle pulse for a new symbol |
| busy | output | 1 | Frame in progress |
| done | output | 1 | Pulse with the last flush chip |
| cfgErr | output | 1 | Pulse on a rejected start |

## Verification
The bound checker watches the port protocol on every cycle. It checks that each symbol follows a strobe, that `inReady` stays low while idle and right after a byte is taken, and that `done` comes with the final symbol and the fall of `busy`. It also checks that an error pulse only follows a rejected start made while idle. The content of the stream can only be shown by the bench scenarios, which compare every emitted symbol against a reference frame built from the requirements. That content covers the inverted and true syncword copies, the encoder taps and flush, the chip patterns for each factor, the latching of M and SF, and the symbol totals. Payload starvation and a start request in mid-frame are also covered only by those scenarios.

// File: rtl/lrfPkg.sv
package lrfPkg;
  localparam int SYNC_BITS = 64;
  localparam logic [SYNC_BITS-1:0] SYNC_WORD = 64'hCCC3_C3CC_C33C_3333;
  localparam int CODE_K = 7;
  localparam int TAIL_BITS = CODE_K - 1;
  localparam logic [CODE_K-1:0] GEN_FIRST  = 7'o171;
  localparam logic [CODE_K-1:0] GEN_SECOND = 7'o133;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SYNC  = 2'd1,
    PH_CHIPS = 2'd2,
    PH_WAIT  = 2'd3
  } phase_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic       clearAll;
    logic       emitSync;
    logic [5:0] syncIdx;
    logic       syncInv;
    logic       emitChip;
    logic       chipOdd;
    logic       codedSel;
    logic       takeInfo;
    logic       takeTail;
    logic       acceptOpen;
  } dpCtrl_t;
endpackage

// File: rtl/lrfControl.sv
module lrfControl
  import lrfPkg::*;
#(
  parameter int REP_W     = 4,
  parameter int REP_RESET = 2,
  parameter int MAX_SF    = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWr,
  input  logic [REP_W-1:0] cfgRep,
  input  logic             startReq,
  input  logic [1:0]       sfSel,
  input  logic             symStrobe,
  input  logic             bitAvail,
  input  logic             bitIsLast,
  output dpCtrl_t          ctrl,
  output logic             busy,
  output logic             done,
  output logic             cfgErr
);
  localparam int CHIP_W = $clog2(MAX_SF);
  localparam int SYNC_W = $clog2(SYNC_BITS);
  localparam int TAIL_W = $clog2(TAIL_BITS + 1);

  phase_t             phase;
  logic [REP_W-1:0]   repCfg;
  logic [REP_W-1:0]   repLat;
  logic [REP_W-1:0]   copyCnt;
  logic [SYNC_W-1:0]  syncCnt;
  logic [CHIP_W-1:0]  chipCnt;
  logic [CHIP_W-1:0]  sfLast;
  logic               codedSel;
  logic               tailMode;
  logic [TAIL_W-1:0]  tailCnt;
  logic               doneR;
  logic               errR;

  logic syncEnd, chipEnd, boundary, tailFinished;
  logic doFinish, doTail, doInfo, startOk;

  always_comb begin
    startOk      = (phase == PH_IDLE) && startReq && (sfSel != 2'b00);
    syncEnd      = (phase == PH_SYNC) && symStrobe &&
                   (syncCnt == SYNC_W'(SYNC_BITS - 1)) && (copyCnt == repLat);
    chipEnd      = (phase == PH_CHIPS) && symStrobe && codedSel && (chipCnt == sfLast);
    boundary     = syncEnd || chipEnd || (phase == PH_WAIT);
    tailFinished = tailMode && (tailCnt == TAIL_W'(TAIL_BITS));
    doFinish     = boundary && tailFinished;
    doTail       = boundary && tailMode && !tailFinished;
    doInfo       = boundary && !tailMode && bitAvail;
  end

  always_comb begin
    ctrl            = '0;
    ctrl.clearAll   = startOk;
    ctrl.emitSync   = (phase == PH_SYNC) && symStrobe;
    ctrl.syncIdx    = 6'(syncCnt);
    ctrl.syncInv    = (copyCnt != repLat);
    ctrl.emitChip   = (phase == PH_CHIPS) && symStrobe;
    ctrl.chipOdd    = chipCnt[0];
    ctrl.codedSel   = codedSel;
    ctrl.takeInfo   = doInfo;
    ctrl.takeTail   = doTail;
    ctrl.acceptOpen = (phase != PH_IDLE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      repCfg <= REP_W'(REP_RESET);
    end else if (cfgWr) begin
      repCfg <= cfgRep;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      repLat   <= '0;
      copyCnt  <= '0;
      syncCnt  <= '0;
      chipCnt  <= '0;
      sfLast   <= '0;
      codedSel <= 1'b0;
      tailMode <= 1'b0;
      tailCnt  <= '0;
      doneR    <= 1'b0;
      errR     <= 1'b0;
    end else begin
      doneR <= 1'b0;
      errR  <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (startReq) begin
            if (sfSel == 2'b00) begin
              errR <= 1'b1;
            end else begin
              phase    <= PH_SYNC;
              repLat   <= repCfg;
              sfLast   <= CHIP_W'((32'd1 << sfSel) - 32'd1);
              copyCnt  <= '0;
              syncCnt  <= '0;
              chipCnt  <= '0;
              codedSel <= 1'b0;
              tailMode <= 1'b0;
              tailCnt  <= '0;
            end
          end
        end
        PH_SYNC: begin
          if (symStrobe) begin
            syncCnt <= syncCnt + 1'b1;
            if (syncCnt == SYNC_W'(SYNC_BITS - 1)) copyCnt <= copyCnt + 1'b1;
            if (syncEnd) phase <= doInfo ? PH_CHIPS : PH_WAIT;
          end
        end
        PH_CHIPS: begin
          if (symStrobe) begin
            if (chipCnt == sfLast) begin
              chipCnt  <= '0;
              codedSel <= ~codedSel;
            end else begin
              chipCnt <= chipCnt + 1'b1;
            end
            if (chipEnd) begin
              if (doFinish) begin
                phase <= PH_IDLE;
                doneR <= 1'b1;
              end else if (doTail || doInfo) begin
                phase <= PH_CHIPS;
              end else begin
                phase <= PH_WAIT;
              end
            end
          end
        end
        PH_WAIT: begin
          if (doInfo) phase <= PH_CHIPS;
        end
        default: phase <= PH_IDLE;
      endcase

      if (doTail) tailCnt <= tailCnt + 1'b1;
      if (doInfo && bitIsLast) begin
        tailMode <= 1'b1;
        tailCnt  <= '0;
      end
    end
  end

  assign busy   = (phase != PH_IDLE);
  assign done   = doneR;
  assign cfgErr = errR;
endmodule

// File: rtl/lrfDatapath.sv
module lrfDatapath
  import lrfPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  dpCtrl_t    ctrl,
  input  logic [7:0] inData,
  input  logic       inValid,
  input  logic       inLast,
  output logic       inReady,
  output logic       bitAvail,
  output logic       bitIsLast,
  output logic       symOut,
  output logic       symValid
);
  logic [7:0]        byteReg;
  logic              byteFull;
  logic              byteLast;
  logic              gotLast;
  logic [2:0]        bitIdx;
  logic [TAIL_BITS-1:0] encSt;   // [TAIL_BITS-1] is the newest past bit
  logic [1:0]        codedPair;
  logic              symOutR;
  logic              symValidR;

  logic              curBit;
  logic [CODE_K-1:0] encVec;
  logic              codeA, codeB;
  logic              chipVal, syncVal;

  always_comb begin
    inReady   = ctrl.acceptOpen && !byteFull && !gotLast;
    bitAvail  = byteFull;
    bitIsLast = byteLast && (bitIdx == 3'd7);
    curBit    = ctrl.takeTail ? 1'b0 : byteReg[bitIdx];
    encVec    = {curBit, encSt};
    codeA     = ^(encVec & GEN_FIRST);
    codeB     = ^(encVec & GEN_SECOND);
    chipVal   = codedPair[ctrl.codedSel] ^ ~ctrl.chipOdd;
    syncVal   = SYNC_WORD[ctrl.syncIdx] ^ ctrl.syncInv;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteReg   <= '0;
      byteFull  <= 1'b0;
      byteLast  <= 1'b0;
      gotLast   <= 1'b0;
      bitIdx    <= '0;
      encSt     <= '0;
      codedPair <= '0;
    end else if (ctrl.clearAll) begin
      byteFull  <= 1'b0;
      byteLast  <= 1'b0;
      gotLast   <= 1'b0;
      bitIdx    <= '0;
      encSt     <= '0;
      codedPair <= '0;
    end else begin
      if (inValid && inReady) begin
        byteReg  <= inData;
        byteFull <= 1'b1;
        byteLast <= inLast;
        gotLast  <= inLast;
        bitIdx   <= '0;
      end
      if (ctrl.takeInfo || ctrl.takeTail) begin
        codedPair <= {codeB, codeA};
        encSt     <= {curBit, encSt[TAIL_BITS-1:1]};
      end
      if (ctrl.takeInfo) begin
        bitIdx <= bitIdx + 1'b1;
        if (bitIdx == 3'd7) byteFull <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      symOutR   <= 1'b0;
      symValidR <= 1'b0;
    end else begin
      symValidR <= ctrl.emitSync || ctrl.emitChip;
      if (ctrl.emitSync)      symOutR <= syncVal;
      else if (ctrl.emitChip) symOutR <= chipVal;
    end
  end

  assign symOut   = symOutR;
  assign symValid = symValidR;
endmodule

// File: rtl/lr_spread_framer.sv
module lr_spread_framer
  import lrfPkg::*;
#(
  parameter int REP_W     = 4,
  parameter int REP_RESET = 2,
  parameter int MAX_SF    = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWr,
  input  logic [REP_W-1:0] cfgRep,
  input  logic             startReq,
  input  logic [1:0]       sfSel,
  input  logic [7:0]       inData,
  input  logic             inValid,
  input  logic             inLast,
  output logic             inReady,
  input  logic             symStrobe,
  output logic             symOut,
  output logic             symValid,
  output logic             busy,
  output logic             done,
  output logic             cfgErr
);
  dpCtrl_t ctrl;
  logic    bitAvail;
  logic    bitIsLast;

  lrfControl #(
    .REP_W(REP_W), .REP_RESET(REP_RESET), .MAX_SF(MAX_SF)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgRep(cfgRep),
    .startReq(startReq), .sfSel(sfSel), .symStrobe(symStrobe),
    .bitAvail(bitAvail), .bitIsLast(bitIsLast), .ctrl(ctrl),
    .busy(busy), .done(done), .cfgErr(cfgErr)
  );

  lrfDatapath u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .inData(inData),
    .inValid(inValid), .inLast(inLast), .inReady(inReady),
    .bitAvail(bitAvail), .bitIsLast(bitIsLast),
    .symOut(symOut), .symValid(symValid)
  );
endmodule

// File: rtl/lrfChecker.sv
module lrfChecker (
  input logic       clk,
  input logic       rstN,
  input logic       startReq,
  input logic [1:0] sfSel,
  input logic       inValid,
  input logic       inReady,
  input logic       symStrobe,
  input logic       symValid,
  input logic       busy,
  input logic       done,
  input logic       cfgErr
);
  assert_err_rejects_R1: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> (!busy && $past(startReq) && ($past(sfSel) == 2'b00)));

  assert_err_idle_only_R10: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> !$past(busy));

  assert_sym_after_strobe_R7: assert property (@(posedge clk) disable iff (!rstN)
    symValid |-> $past(symStrobe));

  assert_idle_no_ready_R8: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !inReady);

  assert_hold_after_accept_R8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> !inReady);

  assert_done_last_sym_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (symValid && !busy && $past(busy)));

  assert_busy_fall_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);
endmodule

bind lr_spread_framer lrfChecker u_chk (.*);

// File: tb/lr_spread_framer_tb.sv
module lr_spread_framer_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWr = 1'b0;
  logic [3:0] cfgRep = '0;
  logic       startReq = 1'b0;
  logic [1:0] sfSel = 2'b00;
  logic [7:0] inData = '0;
  logic       inValid = 1'b0;
  logic       inLast = 1'b0;
  logic       inReady;
  logic       symStrobe = 1'b0;
  logic       symOut, symValid, busy, done, cfgErr;

  always #4 clk = ~clk;

  lr_spread_framer u_dut (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgRep(cfgRep),
    .startReq(startReq), .sfSel(sfSel), .inData(inData),
    .inValid(inValid), .inLast(inLast), .inReady(inReady),
    .symStrobe(symStrobe), .symOut(symOut), .symValid(symValid),
    .busy(busy), .done(done), .cfgErr(cfgErr)
  );

  localparam logic [63:0] REF_SYNC = 64'hCCC3C3CCC33C3333;

  int checks = 0;
  int failures = 0;
  bit got [0:4095];
  bit expv [0:4095];
  int gotN = 0;
  int expN = 0;
  int doneCnt = 0;
  int errCnt = 0;
  logic [7:0] txBytes [0:7];
  bit strobeEn = 1'b0;
  int stbCnt = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Strobe every 4 cycles, driven away from the active edge
  always @(negedge clk) begin
    if (strobeEn) begin
      symStrobe = (stbCnt == 0);
      stbCnt = (stbCnt + 1) % 4;
    end else begin
      symStrobe = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (symValid && gotN < 4096) begin
      got[gotN] = symOut;
      gotN++;
    end
    if (done) doneCnt++;
    if (cfgErr) errCnt++;
  end

  task automatic buildExpected(input int m, input int sf, input int n);
    bit p1, p2, p3, p4, p5, p6, u, ca, cb;
    expN = 0;
    for (int c = 0; c <= m; c++)
      for (int b = 0; b < 64; b++) begin
        expv[expN] = REF_SYNC[b] ^ (c < m);
        expN++;
      end
    {p1, p2, p3, p4, p5, p6} = '0;
    for (int i = 0; i < n * 8 + 6; i++) begin
      u  = (i < n * 8) ? txBytes[i / 8][i % 8] : 1'b0;
      ca = u ^ p1 ^ p2 ^ p3 ^ p6;
      cb = u ^ p2 ^ p3 ^ p5 ^ p6;
      p6 = p5; p5 = p4; p4 = p3; p3 = p2; p2 = p1; p1 = u;
      for (int k = 0; k < sf; k++) begin
        expv[expN] = ca ? (k % 2 == 1) : (k % 2 == 0);
        expN++;
      end
      for (int k = 0; k < sf; k++) begin
        expv[expN] = cb ? (k % 2 == 1) : (k % 2 == 0);
        expN++;
      end
    end
  endtask

  task automatic writeRep(input int m);
    @(negedge clk);
    cfgRep = 4'(m);
    cfgWr = 1'b1;
    @(negedge clk);
    cfgWr = 1'b0;
  endtask

  // Runs one frame; pokeStart pulses a rejected-code start mid-frame (R10)
  task automatic runFrame(input string name, input int m, input logic [1:0] code,
                          input int n, input int gap, input bit pokeStart);
    int sf;
    int mism;
    int firstBad;
    sf = 1 << code;
    gotN = 0; doneCnt = 0; errCnt = 0;
    buildExpected(m, sf, n);
    @(negedge clk);
    sfSel = code;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    fork
      begin
        for (int i = 0; i < n; i++) begin
          int tries;
          repeat (gap) @(negedge clk);
          inData = txBytes[i];
          inLast = (i == n - 1);
          inValid = 1'b1;
          tries = 0;
          while (!inReady && tries < 30000) begin
            @(negedge clk);
            tries++;
          end
          @(negedge clk);
          inValid = 1'b0;
          inLast = 1'b0;
          if (i == n - 1)
            check(!inReady, "R8", {name, " ready after last byte"}, int'(inReady), 0);
        end
      end
      begin
        int cyc;
        cyc = 0;
        while (doneCnt == 0 && cyc < 30000) begin
          @(negedge clk);
          cyc++;
          if (pokeStart && cyc == 120) begin
            sfSel = 2'b00;
            startReq = 1'b1;
          end else if (pokeStart && cyc == 121) begin
            startReq = 1'b0;
          end
        end
        check(cyc < 30000, "R9", {name, " watchdog (done seen)"}, cyc, 0);
      end
    join
    repeat (6) @(negedge clk);
    check(doneCnt == 1, "R9", {name, " done pulses"}, doneCnt, 1);
    check(!busy, "R9", {name, " idle after done"}, int'(busy), 0);
    check(gotN == expN, "R11", {name, " symbol count"}, gotN, expN);
    mism = 0;
    firstBad = -1;
    for (int i = 0; i < expN && i < gotN; i++)
      if (got[i] != expv[i]) begin
        mism++;
        if (firstBad < 0) firstBad = i;
      end
    check(mism == 0, "R3/R4/R5/R6", {name, " stream mismatches (first index in next line)"}, mism, 0);
    if (mism != 0) $display("  first mismatch index %0d", firstBad);
    check(errCnt == 0, "R10", {name, " no error pulse"}, errCnt, 0);
  endtask

  task automatic t_reset;
    check(!busy, "R9", "reset busy", int'(busy), 0);
    check(!inReady, "R8", "reset inReady", int'(inReady), 0);
    check(!symValid, "R7", "reset symValid", int'(symValid), 0);
    check(!done && !cfgErr, "R1", "reset pulses", int'(done | cfgErr), 0);
  endtask

  task automatic t_badSf;
    gotN = 0; errCnt = 0;
    @(negedge clk);
    sfSel = 2'b00;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    repeat (40) @(negedge clk);
    check(errCnt == 1, "R1", "error pulse count", errCnt, 1);
    check(!busy, "R1", "stays idle", int'(busy), 0);
    check(gotN == 0, "R1", "no symbols", gotN, 0);
    check(!inReady, "R8", "idle ready low", int'(inReady), 0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    strobeEn = 1'b1;
    t_badSf();
    // R2 default M=2, R6 SF4
    txBytes[0] = 8'hA5; txBytes[1] = 8'h3C;
    runFrame("defaultM_sf4", 2, 2'b10, 2, 0, 1'b0);
    // R2 write M=0, SF2
    writeRep(0);
    txBytes[0] = 8'h01;
    runFrame("m0_sf2", 0, 2'b01, 1, 0, 1'b0);
    // R7 starvation gaps, M=3, SF8
    writeRep(3);
    txBytes[0] = 8'hFF; txBytes[1] = 8'h00; txBytes[2] = 8'h96;
    runFrame("m3_sf8_starved", 3, 2'b11, 3, 300, 1'b0);
    // R10 start ignored mid-frame, R2 latched value
    writeRep(1);
    txBytes[0] = 8'h5A; txBytes[1] = 8'hC3;
    runFrame("m1_sf2_poke", 1, 2'b01, 2, 0, 1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule